// File: doc/BRIEF.md
# Boot-time USB identity loader from serial EEPROM

This block runs once after every reset. It acts as an I2C master on an open-drain SCL/SDA pair and makes a random read of an 8-byte configuration record from a serial EEPROM. The record holds the vendor ID, the product ID, a configuration attribute byte and a maximum power byte. Its final byte is a signature.

If that signature byte holds the expected value, the record's values are driven on the identity outputs. If it does not, or if the EEPROM fails to acknowledge any address phase, the outputs keep the defaults fixed by parameters. Once the sequence has finished, `done_o` rises and stays high. `loaded_o` shows whether the EEPROM values were taken. The descriptor logic downstream reads the identity outputs once `done_o` is set.

The bus speed comes from a quarter-period divider parameter. Each SCL bit is built from four equal quarters, and SDA is only moved in the quarters where SCL is held low, except for the START and STOP conditions.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is asserted, `vid_o`, `pid_o`, `attr_o` and `max_pwr_o` equal the default parameters, `done_o` and `loaded_o` are 0, and both `scl_oe_o` and `sda_oe_o` are 0 (lines released).
- R2: After reset the master issues a START, then device byte 0xA0 (address 0x50, write), then word address 0x00, then a repeated START, then device byte 0xA1 (read). Each byte is sent MSB first and is followed by an acknowledge bit.
- R3: After 0xA1 is acknowledged, the master reads 8 consecutive bytes with SDA released during the data bits. It drives ACK (SDA low) after bytes 0 to 6 and NACK (SDA released) after byte 7, then issues a STOP.
- R4: Outside START and STOP, SDA changes only while SCL is held low. A complete load shows exactly two START conditions and one STOP.
- R5: Every SCL high pulse lasts exactly 2*QTR_DIV clock cycles, and consecutive SCL rising edges are at least 4*QTR_DIV cycles apart.
- R6: If byte 7 equals 0x58, the outputs are set as follows: `vid_o` = {byte1, byte0}, `pid_o` = {byte3, byte2}, `attr_o` = byte4, `max_pwr_o` = byte5. `loaded_o` is then 1.
- R7: If byte 7 differs from 0x58 in any bit, every output keeps its default, `loaded_o` stays 0 and `done_o` is still set.
- R8: Byte 6 has no effect on any output.
- R9: If the device-write address, the word address or the device-read address is not acknowledged, the master issues a STOP without reading any data. The defaults are kept, `loaded_o` is 0 and `done_o` is set.
- R10: Until `done_o` rises, the identity outputs hold their defaults. Once `done_o` rises, it, `loaded_o` and the identity outputs hold their values and both lines stay released until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| attr_o | output | 8 | Configuration attribute byte |
| max_pwr_o | output | 8 | Maximum power byte |
| done_o | output | 1 | Loading finished (sticky until reset) |
| loaded_o | output | 1 | EEPROM values were applied |

## Verification
The assertions check several rules on every cycle:
- SDA moves only with SCL low during byte transfers.
- The master releases SDA during read data bits.
- The quarter divider stays in range.
- The outputs hold their defaults before `done_o`.
- `loaded_o` never rises without a matching signature.
- `done_o`, the outputs and the idle bus stay frozen once loading has finished.

Other behaviours can only be shown by the bench's scenarios, which run against a modelled EEPROM. These are the exact byte sequence on the wire, the ACK/NACK pattern, and the START/STOP count. The same holds for the byte-to-field mapping across several records, rejection under each single-bit corruption of the signature, the reserved byte having no effect, and the abort at each of the three address phases.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} i2c_op_e;

  typedef enum logic [2:0] {
    SQ_START, SQ_DEVW, SQ_WADDR, SQ_RSTART, SQ_DEVR, SQ_READ, SQ_STOP, SQ_DONE
  } seq_state_e;

  localparam int unsigned REC_BYTES = 8;
  localparam int unsigned IDX_W     = $clog2(REC_BYTES);
  localparam logic [7:0]  SIG_VALUE = 8'h58;
endpackage

// File: rtl/cfg_ldr_tick.sv
module cfg_ldr_tick #(
  parameter int unsigned QTR_DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(QTR_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/cfg_ldr_i2c_phy.sv
module cfg_ldr_i2c_phy import cfg_ldr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  i2c_op_e    op_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_send_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       ack_rx_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       act_q, act_d, done_q, done_d, ackr_q, ackr_d, acks_q, acks_d;
  i2c_op_e    op_q, op_d;
  logic [3:0] bit_q, bit_d;
  logic [1:0] qtr_q, qtr_d;
  logic [7:0] sh_q, sh_d;
  logic       scl_q, sda_q, upd;
  logic [1:0] lv;

  // {scl_oe, sda_oe} for the quarter being entered
  function automatic logic [1:0] lines(i2c_op_e op, logic [1:0] q, logic [3:0] b,
                                       logic d7, logic ak);
    logic low_q;
    low_q = (q == 2'd0) || (q == 2'd3);
    case (op)
      OP_START: return {low_q, q[1]};
      OP_STOP:  return {q == 2'd0, !q[1]};
      OP_WRITE: return {low_q, (b == 4'd8) ? 1'b0 : !d7};
      default:  return {low_q, (b == 4'd8) ? ak : 1'b0};
    endcase
  endfunction

  always_comb begin
    act_d = act_q; op_d = op_q; bit_d = bit_q; qtr_d = qtr_q; sh_d = sh_q;
    ackr_d = ackr_q; acks_d = acks_q; done_d = 1'b0;
    if (!act_q) begin
      if (req_i) begin
        act_d = 1'b1; op_d = op_i; bit_d = '0; qtr_d = '0;
        sh_d = wdata_i; acks_d = ack_send_i;
      end
    end else if (tick_i) begin
      if (qtr_q == 2'd2) begin
        if (op_q == OP_READ && bit_q != 4'd8) sh_d = {sh_q[6:0], sda_i};
        if (op_q == OP_WRITE && bit_q == 4'd8) ackr_d = !sda_i;
      end
      if (qtr_q == 2'd3) begin
        if (op_q == OP_START || op_q == OP_STOP || bit_q == 4'd8) begin
          act_d = 1'b0; done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1; qtr_d = '0;
          if (op_q == OP_WRITE) sh_d = {sh_q[6:0], 1'b0};
        end
      end else begin
        qtr_d = qtr_q + 1'b1;
      end
    end
    upd = act_d && (!act_q || tick_i);
    lv  = lines(op_d, qtr_d, bit_d, sh_d[7], acks_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; op_q <= OP_START; bit_q <= '0; qtr_q <= '0; sh_q <= '0;
      ackr_q <= 1'b0; acks_q <= 1'b0; done_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      act_q <= act_d; op_q <= op_d; bit_q <= bit_d; qtr_q <= qtr_d; sh_q <= sh_d;
      ackr_q <= ackr_d; acks_q <= acks_d; done_q <= done_d;
      if (upd) begin
        scl_q <= lv[1];
        sda_q <= lv[0];
      end
    end
  end

  assign busy_o   = act_q;
  assign done_o   = done_q;
  assign rdata_o  = sh_q;
  assign ack_rx_o = ackr_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_q) && (op_q == OP_WRITE || op_q == OP_READ)) |-> (scl_q && $past(scl_q))); // R4
  AST_RD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && op_q == OP_READ && bit_q != 4'd8) |-> !sda_q); // R3
endmodule

// File: rtl/cfg_ldr_record.sv
module cfg_ldr_record import cfg_ldr_pkg::*; #(
  parameter logic [15:0] DEF_VID  = 16'hC0DE,
  parameter logic [15:0] DEF_PID  = 16'h0A11,
  parameter logic [7:0]  DEF_ATTR = 8'hA0,
  parameter logic [7:0]  DEF_PWR  = 8'h32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic             commit_i,
  output logic [15:0]      vid_o,
  output logic [15:0]      pid_o,
  output logic [7:0]       attr_o,
  output logic [7:0]       pwr_o,
  output logic             loaded_o
);
  logic [7:0] vl_q, vh_q, pl_q, ph_q, at_q, pw_q, sg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q <= '0; vh_q <= '0; pl_q <= '0; ph_q <= '0; at_q <= '0; pw_q <= '0; sg_q <= '0;
    end else if (wr_i) begin
      case (idx_i)
        3'd0: vl_q <= byte_i;
        3'd1: vh_q <= byte_i;
        3'd2: pl_q <= byte_i;
        3'd3: ph_q <= byte_i;
        3'd4: at_q <= byte_i;
        3'd5: pw_q <= byte_i;
        3'd7: sg_q <= byte_i;
        default: ; // reserved byte is dropped
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o <= DEF_VID; pid_o <= DEF_PID; attr_o <= DEF_ATTR; pwr_o <= DEF_PWR;
      loaded_o <= 1'b0;
    end else if (commit_i && sg_q == SIG_VALUE) begin
      vid_o <= {vh_q, vl_q}; pid_o <= {ph_q, pl_q}; attr_o <= at_q; pwr_o <= pw_q;
      loaded_o <= 1'b1;
    end
  end

  AST_LOAD_NEEDS_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |-> (sg_q == SIG_VALUE)); // R6
  AST_DFLT_UNLOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_o |-> (vid_o == DEF_VID && pid_o == DEF_PID && attr_o == DEF_ATTR && pwr_o == DEF_PWR)); // R7
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader import cfg_ldr_pkg::*; #(
  parameter int unsigned QTR_DIV  = 250,
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter logic [15:0] DEF_VID  = 16'hC0DE,
  parameter logic [15:0] DEF_PID  = 16'h0A11,
  parameter logic [7:0]  DEF_ATTR = 8'hA0,
  parameter logic [7:0]  DEF_PWR  = 8'h32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic [15:0] vid_o,
  output logic [15:0] pid_o,
  output logic [7:0]  attr_o,
  output logic [7:0]  max_pwr_o,
  output logic        done_o,
  output logic        loaded_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  seq_state_e       st_q, st_d;
  logic             pend_q, full_q, issue, phy_req, phy_busy, phy_done, phy_ack;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       phy_rdata, wdata;
  i2c_op_e          op;
  logic             tick, rec_wr, commit;

  always_comb begin
    op = OP_START; wdata = '0; issue = 1'b1;
    case (st_q)
      SQ_DEVW:  begin op = OP_WRITE; wdata = {DEV_ADDR, 1'b0}; end
      SQ_WADDR: begin op = OP_WRITE; wdata = 8'h00; end
      SQ_DEVR:  begin op = OP_WRITE; wdata = {DEV_ADDR, 1'b1}; end
      SQ_READ:  op = OP_READ;
      SQ_STOP:  op = OP_STOP;
      SQ_DONE:  issue = 1'b0;
      default:  op = OP_START;
    endcase
  end

  assign phy_req = issue && !pend_q && !phy_busy;
  assign rec_wr  = (st_q == SQ_READ) && phy_done;
  assign commit  = (st_q == SQ_STOP) && phy_done && full_q;

  always_comb begin
    st_d = st_q;
    if (phy_done) begin
      case (st_q)
        SQ_START:  st_d = SQ_DEVW;
        SQ_DEVW:   st_d = phy_ack ? SQ_WADDR : SQ_STOP;
        SQ_WADDR:  st_d = phy_ack ? SQ_RSTART : SQ_STOP;
        SQ_RSTART: st_d = SQ_DEVR;
        SQ_DEVR:   st_d = phy_ack ? SQ_READ : SQ_STOP;
        SQ_READ:   st_d = (idx_q == LAST_IDX) ? SQ_STOP : SQ_READ;
        SQ_STOP:   st_d = SQ_DONE;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_START; pend_q <= 1'b0; idx_q <= '0; full_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (phy_req)       pend_q <= 1'b1;
      else if (phy_done) pend_q <= 1'b0;
      if (rec_wr) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) full_q <= 1'b1;
      end
    end
  end

  cfg_ldr_tick #(.QTR_DIV(QTR_DIV)) i_tick (
    .clk_i, .rst_ni, .en_i(phy_busy), .tick_o(tick)
  );

  cfg_ldr_i2c_phy i_phy (
    .clk_i, .rst_ni, .tick_i(tick), .req_i(phy_req), .op_i(op), .wdata_i(wdata),
    .ack_send_i(idx_q != LAST_IDX), .sda_i, .busy_o(phy_busy), .done_o(phy_done),
    .rdata_o(phy_rdata), .ack_rx_o(phy_ack), .scl_oe_o, .sda_oe_o
  );

  cfg_ldr_record #(
    .DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_ATTR(DEF_ATTR), .DEF_PWR(DEF_PWR)
  ) i_rec (
    .clk_i, .rst_ni, .wr_i(rec_wr), .idx_i(idx_q), .byte_i(phy_rdata), .commit_i(commit),
    .vid_o, .pid_o, .attr_o, .pwr_o(max_pwr_o), .loaded_o
  );

  assign done_o = (st_q == SQ_DONE);

  AST_DFLT_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (vid_o == DEF_VID && pid_o == DEF_PID && attr_o == DEF_ATTR && max_pwr_o == DEF_PWR)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(loaded_o) && $stable(vid_o) && $stable(pid_o))); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scl_oe_o && !sda_oe_o)); // R10
  AST_LOADED_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |-> done_o); // R6
endmodule

// File: tb/test_cfg_eeprom_loader.sv
module test_cfg_eeprom_loader;
  localparam int unsigned QTR = 2;
  localparam logic [15:0] D_VID = 16'hC0DE, D_PID = 16'h0A11;
  localparam logic [7:0]  D_ATTR = 8'hA0, D_PWR = 8'h32;
  localparam int S_IDLE = 0, S_ADDR = 1, S_WORD = 2, S_READ = 3;
  localparam time TCK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_oe, sda_oe, done, loaded, sl_drv = 1'b0;
  logic [15:0] vid, pid;
  logic [7:0] attr, pwr;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || sl_drv);

  cfg_eeprom_loader #(.QTR_DIV(QTR), .DEF_VID(D_VID), .DEF_PID(D_PID),
                      .DEF_ATTR(D_ATTR), .DEF_PWR(D_PWR)) i_cfg_eeprom_loader (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .vid_o(vid), .pid_o(pid), .attr_o(attr), .max_pwr_o(pwr), .done_o(done), .loaded_o(loaded)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // EEPROM model
  logic [7:0] mem [8];
  logic [7:0] sh = '0, cur = '0;
  logic [7:0] rx_log [4];
  int st = S_IDLE, bc = 0, n_rx = 0, n_rd = 0, n_ack = 0, n_nack = 0;
  int n_start = 0, n_stop = 0, nack_stage = 0, hi_bad = 0, per_bad = 0, dflt_bad = 0;
  int unsigned ptr = 0;
  logic armed = 1'b1, m_ack = 1'b0, acked, seen_rise = 1'b0;
  time t_rise = 0;

  function automatic logic want_ack(int s, logic [7:0] b);
    if (s == S_WORD) return nack_stage != 2;
    if (b[7:1] != 7'h50) return 1'b0;
    if (!b[0]) return nack_stage != 1;
    return nack_stage != 3;
  endfunction

  always @(negedge sda) if (scl) begin
    n_start++; st = S_ADDR; bc = 0; armed = 1'b0; sl_drv = 1'b0;
  end
  always @(posedge sda) if (scl) begin
    n_stop++; st = S_IDLE; sl_drv = 1'b0;
  end

  always @(posedge scl) begin
    if (seen_rise && ($time - t_rise) < 4 * QTR * TCK) per_bad++;
    t_rise = $time; seen_rise = 1'b1;
    if (st != S_IDLE) begin
      if (bc < 8) begin
        if (st != S_READ) sh = {sh[6:0], sda};
      end else if (st == S_READ) m_ack = !sda;
    end
  end

  always @(negedge scl) begin
    if (seen_rise && ($time - t_rise) != 2 * QTR * TCK) hi_bad++;
    if (!armed) armed = 1'b1;
    else if (st != S_IDLE) begin
      if (bc < 7) begin
        bc++;
        if (st == S_READ) sl_drv = !cur[7-bc];
      end else if (bc == 7) begin
        bc = 8;
        if (st == S_READ) sl_drv = 1'b0;
        else begin
          if (n_rx < 4) rx_log[n_rx] = sh;
          n_rx++;
          sl_drv = want_ack(st, sh);
        end
      end else begin
        bc = 0;
        acked = sl_drv;
        sl_drv = 1'b0;
        if (st == S_READ) begin
          n_rd++;
          if (m_ack) begin
            n_ack++; ptr = (ptr + 1) % 8; cur = mem[ptr]; sl_drv = !cur[7];
          end else begin
            n_nack++; st = S_IDLE;
          end
        end else if (!acked) st = S_IDLE;
        else if (st == S_ADDR) begin
          if (sh[0]) begin st = S_READ; cur = mem[ptr]; sl_drv = !cur[7]; end
          else st = S_WORD;
        end else begin
          ptr = int'(sh[2:0]); st = S_IDLE;
        end
      end
    end
  end

  always @(negedge clk)
    if (rst_n && !done && (vid != D_VID || pid != D_PID || attr != D_ATTR || pwr != D_PWR))
      dflt_bad++;

  task automatic run_case(input string tag, input int ns);
    logic good;
    logic [15:0] e_vid, e_pid;
    logic [7:0] e_attr, e_pwr;
    int e_rx;
    logic [7:0] e_byte [3];
    logic [15:0] h_vid;
    logic h_load;
    nack_stage = ns;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_rx = 0; n_rd = 0; n_ack = 0; n_nack = 0; n_start = 0; n_stop = 0;
    hi_bad = 0; per_bad = 0; dflt_bad = 0; seen_rise = 1'b0; st = S_IDLE; sl_drv = 1'b0;
    chk(vid == D_VID && pid == D_PID && attr == D_ATTR && pwr == D_PWR, "R1", {tag, " defaults"},
        {vid, pid}, {D_VID, D_PID});
    chk(!done && !loaded && !scl_oe && !sda_oe, "R1", {tag, " flags/lines"},
        {28'd0, done, loaded, scl_oe, sda_oe}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done, "R10", {tag, " done"}, {31'd0, done}, 32'd1);
    chk(dflt_bad == 0, "R10", {tag, " defaults before done"}, dflt_bad, 0);

    good = (ns == 0) && (mem[7] == 8'h58);
    e_rx = (ns == 1) ? 1 : (ns == 2) ? 2 : 3;
    e_byte[0] = 8'hA0; e_byte[1] = 8'h00; e_byte[2] = 8'hA1;
    chk(n_rx == e_rx, "R2", {tag, " addr bytes seen"}, n_rx, e_rx);
    for (int i = 0; i < 3; i++)
      if (i < e_rx && i < n_rx) chk(rx_log[i] == e_byte[i], "R2", {tag, " addr byte"}, rx_log[i], e_byte[i]);
    if (ns == 0) begin
      chk(n_rd == 8 && n_ack == 7 && n_nack == 1, "R3", {tag, " reads/acks/nack"},
          {8'(n_rd), 8'(n_ack), 8'(n_nack), 8'd0}, {8'd8, 8'd7, 8'd1, 8'd0});
    end else begin
      chk(n_rd == 0, "R9", {tag, " no data read after nack"}, n_rd, 0);
    end
    chk(n_start == ((ns == 0 || ns == 3) ? 2 : 1), "R4", {tag, " start count"}, n_start,
        (ns == 0 || ns == 3) ? 2 : 1);
    chk(n_stop == 1 && st == S_IDLE, "R4", {tag, " stop count"}, n_stop, 1);
    chk(hi_bad == 0 && per_bad == 0, "R5", {tag, " scl timing"}, {hi_bad[15:0], per_bad[15:0]}, 0);

    e_vid = good ? {mem[1], mem[0]} : D_VID;
    e_pid = good ? {mem[3], mem[2]} : D_PID;
    e_attr = good ? mem[4] : D_ATTR;
    e_pwr = good ? mem[5] : D_PWR;
    chk(vid == e_vid && pid == e_pid, good ? "R6" : (ns != 0 ? "R9" : "R7"),
        {tag, " ids"}, {vid, pid}, {e_vid, e_pid});
    chk(attr == e_attr && pwr == e_pwr, good ? "R6" : (ns != 0 ? "R9" : "R7"),
        {tag, " attr/pwr"}, {16'd0, attr, pwr}, {16'd0, e_attr, e_pwr});
    chk(loaded == good, "R6", {tag, " loaded flag"}, {31'd0, loaded}, {31'd0, good});

    h_vid = vid; h_load = loaded;
    repeat (25) @(negedge clk);
    chk(done && !scl_oe && !sda_oe && vid == h_vid && loaded == h_load, "R10",
        {tag, " frozen after done"}, {29'd0, done, scl_oe, sda_oe}, 32'd4);
  endtask

  bit finished = 1'b0;
  initial begin
    #(200000 * TCK);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: several records swept arithmetically
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 7; i++) mem[i] = 8'(p * 53 + i * 29 + 7);
      mem[7] = 8'h58;
      run_case($sformatf("rec%0d", p), 0);
    end
    // R8: reserved byte changed, same other bytes
    for (int i = 0; i < 7; i++) mem[i] = 8'(i * 29 + 7);
    mem[7] = 8'h58;
    for (int v = 0; v < 3; v++) begin
      mem[6] = 8'(v * 85);
      run_case($sformatf("R8_rsvd%0d", v), 0);
    end
    // R7: every single-bit corruption of the signature
    for (int k = 0; k < 8; k++) begin
      mem[7] = 8'h58 ^ (8'h01 << k);
      run_case($sformatf("R7_sigbit%0d", k), 0);
    end
    // R9: nack at each address phase
    mem[7] = 8'h58;
    for (int s = 1; s <= 3; s++) run_case($sformatf("R9_nack%0d", s), s);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule